// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block turns a fast system clock into the serial clock timing for an SPI master. It has two stages. A prescaler counts system cycles and gives a one-cycle tick each time it wraps. A phase counter advances only on that tick and wraps at a programmed limit. Two compare points on the phase counter set where the serial clock level rises and where it falls, so one set of fields sets both the period and the duty. The serial clock has an idle level of low; any inversion for clock polarity is done downstream.

The output is a registered level plus one-cycle rise and fall strobes, which the shift logic uses as clock enables. When the transaction engine is idle (`run` low), both counters are held at zero, so every transfer starts on the same phase. Divider fields are copied into shadow registers only while idle, in bypass, or at the phase counter's wrap. A change made during a transfer therefore never makes a short pulse. A bypass flag skips both stages. The shift logic then gets a rise and a fall strobe on every system cycle, which is the full system rate.

Software loads each divide field with its division value minus one. For about 50% duty, the high point is half the counter division value and the low point is zero.

Top module: `sclk_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sclk_lvl`, `sclk_rise` and `sclk_fall` are all 0 after that edge.
- R2: While `run` is low, all three outputs are 0 and both counters are held at zero. Number the clock edges that see `run` high, starting at 1. The first rise strobe then appears after edge `1 + P + H*(P+1)`, where P is `pre_div` and H is `cnt_high`. This is the same for every start, including a restart in the middle of a period.
- R3: Outside bypass, two consecutive rise strobes are `(P+1)*(W+1)` system cycles apart, where W is `cnt_wrap`.
- R4: Outside bypass, with H different from L (`cnt_low`), the level stays high for `((L - H) mod (W+1)) * (P+1)` cycles. With L = 0 this is `(W+1-H)*(P+1)`.
- R5: Outside bypass, `sclk_rise` is high for exactly the cycle in which `sclk_lvl` has just gone from 0 to 1. `sclk_fall` is high for exactly the cycle in which it has just gone from 1 to 0. The two are never high together, and the level never changes without a strobe.
- R6: The phase counter and the level change only after an edge at which the prescaler tick was high.
- R7: A change to the divider fields during a transfer takes effect only from the phase counter's wrap. The period in progress finishes with the old values.
- R8: In bypass with `run` high, `sclk_rise` and `sclk_fall` are both 1 on every cycle from the first edge onward, and `sclk_lvl` stays 0. With `run` low, bypass produces no strobes.
- R9: If H equals L, the high point wins: the level rises and then stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Transaction engine active; low holds both counters at zero |
| bypass_en | input | 1 | Full system-rate mode; skips both divider stages |
| pre_div | input | PRE_W | Prescale division value minus one |
| cnt_wrap | input | CNT_W | Phase counter division value minus one |
| cnt_high | input | CNT_W | Phase count at which the level goes high |
| cnt_low | input | CNT_W | Phase count at which the level goes low |
| sclk_lvl | output | 1 | Serial clock level (idle low) |
| sclk_rise | output | 1 | One-cycle strobe for a rising serial clock edge |
| sclk_fall | output | 1 | One-cycle strobe for a falling serial clock edge |

## Verification
The assertions check these on every cycle:
- Both counters stay within their shadowed limits.
- The phase counter and the level move only after a prescaler tick.
- The strobes agree with the level, and never both fire outside bypass.
- Idle forces all outputs low.

Only the bench's scenarios can show the arithmetic:
- the first-rise latency;
- the period and high time for each combination of prescale, wrap and high point;
- that a field change during a transfer waits for the wrap.

The bench also shows the bypass strobe pattern.

// File: rtl/sclk_div_pkg.sv
// Package: shared types for the serial clock divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sclk_div_pkg;

    // Action the edge generator takes on a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RISE  = 2'd1,
        ACT_FALL  = 2'd2,
        ACT_BURST = 2'd3
    } edge_act_e;

endpackage

// File: rtl/sclk_prescaler.sv
// Module: first divider stage. Counts system cycles up to a limit. Gives a
// one-cycle tick on the cycle the count reaches the limit, then wraps to zero.
// Assumes: the limit is changed only while the count is zero, or on the tick
// cycle (the shadow logic in the top guarantees this).
module sclk_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [PRE_W-1:0] limit_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] pcnt_q;
    logic             at_limit;

    assign at_limit = (pcnt_q == limit_i);
    assign tick_o   = !hold_i && at_limit;

    // Advance the prescale count; clear it when held or at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (hold_i || at_limit) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R3: the prescale count never passes its limit
    a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= limit_i);

    // R2: a hold returns the count to zero on the next edge
    a_r2_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (pcnt_q == '0));

endmodule

// File: rtl/sclk_phase_counter.sv
// Module: second divider stage. Advances one step per prescaler tick and wraps
// to zero after the wrap limit. Flags the wrap cycle so the top can reload
// the shadowed fields.
// Assumes: tick_i is already low while hold_i is high.
module sclk_phase_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] wrap_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] ccnt_q;

    assign count_o = ccnt_q;
    assign wrap_o  = tick_i && (ccnt_q == wrap_i);

    // Step the phase count on each tick; clear it when held or wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccnt_q <= '0;
        end else if (hold_i || wrap_o) begin
            ccnt_q <= '0;
        end else if (tick_i) begin
            ccnt_q <= ccnt_q + 1'b1;
        end
    end

    // R3: the phase count never passes the wrap limit
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ccnt_q <= wrap_i);

    // R6: without a tick the phase count keeps its value
    a_r6_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hold_i && !tick_i) |-> $stable(ccnt_q));

endmodule

// File: rtl/sclk_edge_gen.sv
// Module: turns phase-count matches into a registered serial clock level and
// one-cycle rise and fall strobes. The high point takes priority over the
// low point. A strobe fires only on a real change of level. In bypass, both
// strobes fire on every cycle and the level stays low.
// Assumes: count_i, high_i and low_i come from the shadowed configuration.
module sclk_edge_gen
    import sclk_div_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             byp_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [CNT_W-1:0] low_i,
    output logic             lvl_o,
    output logic             rise_o,
    output logic             fall_o
);

    edge_act_e act;

    // Pick this cycle's action from mode, tick and compare matches.
    always_comb begin
        act = ACT_HOLD;
        if (byp_i) begin
            act = ACT_BURST;
        end else if (tick_i && (count_i == high_i) && !lvl_o) begin
            act = ACT_RISE;
        end else if (tick_i && (count_i == low_i) && (count_i != high_i) && lvl_o) begin
            act = ACT_FALL;
        end
    end

    // Register level and strobes; idle forces everything low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            lvl_o  <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            unique case (act)
                ACT_RISE: begin
                    lvl_o  <= 1'b1;
                    rise_o <= 1'b1;
                    fall_o <= 1'b0;
                end
                ACT_FALL: begin
                    lvl_o  <= 1'b0;
                    rise_o <= 1'b0;
                    fall_o <= 1'b1;
                end
                ACT_BURST: begin
                    lvl_o  <= 1'b0;
                    rise_o <= 1'b1;
                    fall_o <= 1'b1;
                end
                default: begin
                    rise_o <= 1'b0;
                    fall_o <= 1'b0;
                end
            endcase
        end
    end

    // R2: idle leaves all outputs low after the next edge
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!lvl_o && !rise_o && !fall_o));

    // R5: a lone rise strobe marks a 0 to 1 change of level
    a_r5_rise_marks_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && !fall_o) |-> (lvl_o && !$past(lvl_o)));

    // R5: a lone fall strobe marks a 1 to 0 change of level
    a_r5_fall_marks_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o && !rise_o) |-> (!lvl_o && $past(lvl_o)));

    // R5: both strobes together only after a bypass cycle
    a_r5_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && fall_o) |-> $past(byp_i && run_i));

    // R6: the level holds unless the previous edge saw a tick
    a_r6_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_i && !byp_i && !tick_i) |-> $stable(lvl_o));

    // R8: bypass keeps the level low
    a_r8_bypass_low: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && byp_i) |=> !lvl_o);

endmodule

// File: rtl/sclk_divider.sv
// Module: top of the serial clock divider. Shadows the divider fields and
// chains the prescaler, phase counter and edge generator. The shadow copy
// loads while idle, in bypass, or on the phase counter's wrap. A field change
// during a transfer therefore takes effect at the period boundary.
// Assumes: run is low between transfers; fields are static values minus one.
module sclk_divider #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bypass_en,
    input  logic [PRE_W-1:0] pre_div,
    input  logic [CNT_W-1:0] cnt_wrap,
    input  logic [CNT_W-1:0] cnt_high,
    input  logic [CNT_W-1:0] cnt_low,
    output logic             sclk_lvl,
    output logic             sclk_rise,
    output logic             sclk_fall
);

    logic [PRE_W-1:0] sh_pre;
    logic [CNT_W-1:0] sh_wrap;
    logic [CNT_W-1:0] sh_high;
    logic [CNT_W-1:0] sh_low;
    logic             sh_byp;
    logic             shadow_load;
    logic             stage_hold;
    logic             pre_tick;
    logic             phase_wrap;
    logic [CNT_W-1:0] phase_cnt;

    assign stage_hold  = !run || sh_byp;
    assign shadow_load = stage_hold || phase_wrap;

    // Copy the divider fields into the shadow at safe points only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre  <= '0;
            sh_wrap <= '0;
            sh_high <= '0;
            sh_low  <= '0;
            sh_byp  <= 1'b0;
        end else if (shadow_load) begin
            sh_pre  <= pre_div;
            sh_wrap <= cnt_wrap;
            sh_high <= cnt_high;
            sh_low  <= cnt_low;
            sh_byp  <= bypass_en;
        end
    end

    sclk_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (stage_hold),
        .limit_i (sh_pre),
        .tick_o  (pre_tick)
    );

    sclk_phase_counter #(.CNT_W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (stage_hold),
        .tick_i  (pre_tick),
        .wrap_i  (sh_wrap),
        .count_o (phase_cnt),
        .wrap_o  (phase_wrap)
    );

    sclk_edge_gen #(.CNT_W(CNT_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .byp_i   (sh_byp),
        .tick_i  (pre_tick),
        .count_i (phase_cnt),
        .high_i  (sh_high),
        .low_i   (sh_low),
        .lvl_o   (sclk_lvl),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    // R7: the wrap limit in use changes only on a wrap or while held
    a_r7_shadow_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stage_hold || phase_wrap) |-> $stable(sh_wrap));

    // R1: outputs are low after a reset edge
    a_r1_reset_low: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sclk_lvl && !sclk_rise && !sclk_fall));

endmodule

// File: tb/sclk_divider_tb_top.sv
// Bench: sweeps small divider settings and compares the first-rise latency,
// period and high time against values computed from the requirements.
module sclk_divider_tb_top;

    localparam int PRE_W = 8;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic             bypass_en = 1'b0;
    logic [PRE_W-1:0] pre_div = '0;
    logic [CNT_W-1:0] cnt_wrap = '0;
    logic [CNT_W-1:0] cnt_high = '0;
    logic [CNT_W-1:0] cnt_low = '0;
    logic             sclk_lvl;
    logic             sclk_rise;
    logic             sclk_fall;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sclk_divider #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .bypass_en (bypass_en),
        .pre_div   (pre_div),
        .cnt_wrap  (cnt_wrap),
        .cnt_high  (cnt_high),
        .cnt_low   (cnt_low),
        .sclk_lvl  (sclk_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_fields(input int p, input int w, input int h, input int l);
        pre_div  = PRE_W'(p);
        cnt_wrap = CNT_W'(w);
        cnt_high = CNT_W'(h);
        cnt_low  = CNT_W'(l);
    endtask

    // One transfer: measure first rise, second rise and first fall after the first rise.
    task automatic run_cfg(input int p, input int w, input int h, input int l);
        int n;
        int r1;
        int r2;
        int f1;
        int hi_ticks;
        logic prev;
        bit bad;
        @(negedge clk);
        run = 1'b0;
        bypass_en = 1'b0;
        set_fields(p, w, h, l);
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        n = 0; r1 = 0; r2 = 0; f1 = 0; prev = 1'b0; bad = 1'b0;
        while (r2 == 0 && n < 400) begin
            @(negedge clk);
            n++;
            if (sclk_rise && (!sclk_lvl || prev)) bad = 1'b1;
            if (sclk_fall && (sclk_lvl || !prev)) bad = 1'b1;
            if ((sclk_lvl != prev) && !sclk_rise && !sclk_fall) bad = 1'b1;
            if (sclk_rise && sclk_fall) bad = 1'b1;
            if (sclk_rise) begin
                if (r1 == 0) r1 = n;
                else r2 = n;
            end
            if (sclk_fall && r1 != 0 && f1 == 0) f1 = n;
            prev = sclk_lvl;
        end
        run = 1'b0;
        hi_ticks = (l - h + w + 1) % (w + 1);
        chk(r1 == 1 + p + h * (p + 1), "R2 first rise", r1, 1 + p + h * (p + 1));
        chk(r2 - r1 == (p + 1) * (w + 1), "R3 period", r2 - r1, (p + 1) * (w + 1));
        chk(f1 - r1 == hi_ticks * (p + 1), "R4 high time", f1 - r1, hi_ticks * (p + 1));
        chk(!bad, "R5 strobe/level agreement", int'(bad), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int r_a;
        int r_b;
        int r_c;
        int n;
        bit ok;

        // R1: reset with live inputs keeps outputs low
        set_fields(0, 1, 1, 0);
        run = 1'b1;
        bypass_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sclk_lvl && !sclk_rise && !sclk_fall, "R1 reset outputs",
            int'({sclk_lvl, sclk_rise, sclk_fall}), 0);
        run = 1'b0;
        bypass_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sclk_lvl && !sclk_rise && !sclk_fall, "R2 idle outputs",
            int'({sclk_lvl, sclk_rise, sclk_fall}), 0);

        // R2 R3 R4 R5: sweep prescale, wrap and high point with low at zero
        for (int p = 0; p < 4; p++) begin
            for (int w = 1; w < 5; w++) begin
                for (int h = 1; h <= w; h++) begin
                    run_cfg(p, w, h, 0);
                end
            end
        end

        // R4: nonzero low points, both above and below the high point
        for (int l = 2; l < 6; l++) run_cfg(1, 5, 1, l);
        run_cfg(1, 5, 4, 2);
        run_cfg(2, 3, 3, 1);

        // R2: restart in the middle of a period gives the same first rise
        @(negedge clk);
        set_fields(1, 3, 2, 0);
        run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(!sclk_lvl && !sclk_rise && !sclk_fall, "R2 idle after drop",
            int'({sclk_lvl, sclk_rise, sclk_fall}), 0);
        run = 1'b1;
        n = 0; r_a = 0;
        while (r_a == 0 && n < 50) begin
            @(negedge clk);
            n++;
            if (sclk_rise) r_a = n;
        end
        chk(r_a == 6, "R2 restart first rise", r_a, 6);
        run = 1'b0;

        // R7: field change after the first rise waits for the wrap
        @(negedge clk);
        set_fields(0, 3, 2, 0);
        @(negedge clk);
        run = 1'b1;
        n = 0; r_a = 0; r_b = 0; r_c = 0;
        while (r_c == 0 && n < 50) begin
            @(negedge clk);
            n++;
            if (sclk_rise) begin
                if (r_a == 0) begin
                    r_a = n;
                    set_fields(0, 1, 1, 0);
                end else if (r_b == 0) begin
                    r_b = n;
                end else begin
                    r_c = n;
                end
            end
        end
        run = 1'b0;
        chk(r_a == 3, "R7 first rise old fields", r_a, 3);
        chk(r_b - r_a == 3, "R7 old period finishes", r_b - r_a, 3);
        chk(r_c - r_b == 2, "R7 new period after wrap", r_c - r_b, 2);

        // R9: equal high and low points leave the level high
        @(negedge clk);
        set_fields(0, 3, 1, 1);
        @(negedge clk);
        run = 1'b1;
        ok = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!sclk_lvl || sclk_fall) ok = 1'b0;
        end
        run = 1'b0;
        chk(ok, "R9 high point wins", int'(ok), 1);

        // R8: bypass gives both strobes every cycle with the level low
        @(negedge clk);
        set_fields(3, 4, 2, 0);
        bypass_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sclk_rise && !sclk_fall, "R8 bypass idle no strobes",
            int'({sclk_rise, sclk_fall}), 0);
        run = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!sclk_rise || !sclk_fall || sclk_lvl) ok = 1'b0;
        end
        chk(ok, "R8 bypass strobes every cycle", int'(ok), 1);
        run = 1'b0;
        bypass_en = 1'b0;

        // R3: divided mode again after bypass
        run_cfg(1, 2, 1, 0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule